// File: doc/BRIEF.md
# Request-Paced Memory-to-Peripheral Byte Mover

This block is one channel of direct memory access that streams bytes from memory into a single peripheral data register. Software programs a fixed destination address, a starting memory address and a byte count through a small register bus, then sets the channel's enable bit last. From then on each request from the peripheral moves exactly one byte. The move is a memory read at the current memory address followed by a write of that byte to the fixed destination. The peripheral sees a one-cycle acknowledge with the write.

The channel counts down as it goes. It raises a half-way flag when the remaining count first reaches half of the programmed count, rounded down. It raises a completion flag when the count reaches zero. Both flags are sticky and are cleared by writing ones to the status register, and each can drive the level interrupt output through its own enable. Once the count is exhausted the channel ignores further requests. A priority field is kept for a surrounding arbiter but has no effect inside the channel.

Top module: `dma_chan_m2p`

## Requirements
- R1: After reset the channel is disabled, every register reads zero, `mst_valid`, `periph_ack` and `irq` are low.
- R2: Register select 0 is control: bit 0 enable, bit 1 half-way interrupt enable, bit 2 completion interrupt enable, bits 5:4 priority (stored only). Select 1 is the destination address. Select 2 is the current memory address. Select 3 is the remaining count, 16 bits. Select 4 is status: bit 0 half-way flag, bit 1 completion flag. Other selects read zero. `reg_rdata` reflects `reg_sel` combinationally.
- R3: The enable bit is always writable. Writes to every other control field, to the destination, to the memory address and to the count are ignored while the channel is enabled or a transfer is in flight.
- R4: A transfer starts only from idle, with the channel enabled, the count non-zero and `periph_req` high. It is one read at the current memory address and then one write of the byte read to the destination address.
- R5: The master port holds `mst_valid`, `mst_we`, `mst_addr` and `mst_wdata` steady until `mst_ready` is seen high.
- R6: `periph_ack` is high only in the cycle in which the peripheral write is accepted. On that edge the count drops by one and the memory address rises by one. The destination address never changes.
- R7: The half-way flag sets on the edge where the count becomes floor(N/2), with N the last programmed count. With N of 1 it sets together with completion.
- R8: The completion flag sets on the edge where the count becomes zero. With a zero count, requests start no transfer and the count and addresses stay unchanged.
- R9: Both flags stay set until a status write with a one in their bit position. When a flag is set and cleared in the same cycle, the set wins.
- R10: `irq` is high exactly when (half-way flag and its enable) or (completion flag and its enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register |
| periph_req | input | 1 | Peripheral asks for one byte |
| periph_ack | output | 1 | Pulse: byte written to the peripheral |
| mst_valid | output | 1 | Master port transaction pending |
| mst_we | output | 1 | 1 = write to peripheral, 0 = memory read |
| mst_addr | output | 32 | Transaction address |
| mst_wdata | output | 8 | Write data |
| mst_rdata | input | 8 | Read data, taken when `mst_ready` is high |
| mst_ready | input | 1 | Transaction accepted this cycle |
| irq | output | 1 | Level interrupt |

## Verification
Master port signals, `periph_ack`, `irq` and `reg_rdata` are combinational from the registered state, so they can be checked in the same cycle. Counter, address and flag updates appear one edge after the cycle in which the write was accepted. A request seen in idle produces the read phase one edge later. The bench drives every input on the falling edge. On the next falling edge it first advances its behavioural model across the rising edge that lay between, and then compares every output against it. Each effect is therefore checked in the first cycle it is due, never earlier or later. Named register readbacks at fixed points add checks with hand-computed values for counts, addresses and flags.

// File: rtl/dma_m2p_pkg.sv
package dma_m2p_pkg;

    // transfer engine phases
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    localparam int SEL_W = 3;

    // register selects
    localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_DEST  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_MEM   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_COUNT = 3'd3;
    localparam logic [SEL_W-1:0] SEL_STAT  = 3'd4;

    // control bit positions
    localparam int CTRL_EN       = 0;
    localparam int CTRL_HALF_IE  = 1;
    localparam int CTRL_DONE_IE  = 2;
    localparam int CTRL_PRIO_LSB = 4;

    // status bit positions
    localparam int STAT_HALF = 0;
    localparam int STAT_DONE = 1;

endpackage

// File: rtl/dma_m2p_regs.sv
module dma_m2p_regs
    import dma_m2p_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CW    = 16,
    parameter int PW    = 2,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             step,
    input  logic             busy,
    output logic             chan_en,
    output logic [AW-1:0]    dest_addr,
    output logic [AW-1:0]    mem_addr,
    output logic             cnt_nz,
    output logic             irq
);

    localparam logic [CW-1:0] CNT_ONE  = {{(CW-1){1'b0}}, 1'b1};
    localparam logic [AW-1:0] ADDR_ONE = {{(AW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic          en;
        logic          half_ie;
        logic          done_ie;
        logic [PW-1:0] prio;
        logic [AW-1:0] dest;
        logic [AW-1:0] mem;
        logic [CW-1:0] cnt;
        logic [CW-1:0] half_mark;
        logic          half_flag;
        logic          done_flag;
    } regs_t;

    regs_t         regs_d, regs_q;
    logic          cfg_open;
    logic [CW-1:0] cnt_less;
    logic          unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign cnt_less     = regs_q.cnt - CNT_ONE;

    always_comb begin
        regs_d   = regs_q;
        cfg_open = !regs_q.en && !busy;

        if (reg_wr) begin
            case (reg_sel)
                SEL_CTRL: begin
                    regs_d.en = reg_wdata[CTRL_EN];
                    if (cfg_open) begin
                        regs_d.half_ie = reg_wdata[CTRL_HALF_IE];
                        regs_d.done_ie = reg_wdata[CTRL_DONE_IE];
                        regs_d.prio    = reg_wdata[CTRL_PRIO_LSB +: PW];
                    end
                end
                SEL_DEST: if (cfg_open) regs_d.dest = reg_wdata[AW-1:0];
                SEL_MEM:  if (cfg_open) regs_d.mem  = reg_wdata[AW-1:0];
                SEL_COUNT: begin
                    if (cfg_open) begin
                        regs_d.cnt       = reg_wdata[CW-1:0];
                        regs_d.half_mark = reg_wdata[CW-1:0] >> 1;
                    end
                end
                SEL_STAT: begin
                    if (reg_wdata[STAT_HALF]) regs_d.half_flag = 1'b0;
                    if (reg_wdata[STAT_DONE]) regs_d.done_flag = 1'b0;
                end
                default: ;
            endcase
        end

        // a finished byte: flags set after the clear so that setting wins
        if (step && (regs_q.cnt != '0)) begin
            regs_d.cnt = cnt_less;
            regs_d.mem = regs_q.mem + ADDR_ONE;
            if (cnt_less == regs_q.half_mark) regs_d.half_flag = 1'b1;
            if (cnt_less == '0)               regs_d.done_flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CTRL: begin
                reg_rdata[CTRL_EN]               = regs_q.en;
                reg_rdata[CTRL_HALF_IE]          = regs_q.half_ie;
                reg_rdata[CTRL_DONE_IE]          = regs_q.done_ie;
                reg_rdata[CTRL_PRIO_LSB +: PW]   = regs_q.prio;
            end
            SEL_DEST:  reg_rdata[AW-1:0] = regs_q.dest;
            SEL_MEM:   reg_rdata[AW-1:0] = regs_q.mem;
            SEL_COUNT: reg_rdata[CW-1:0] = regs_q.cnt;
            SEL_STAT: begin
                reg_rdata[STAT_HALF] = regs_q.half_flag;
                reg_rdata[STAT_DONE] = regs_q.done_flag;
            end
            default: ;
        endcase
    end

    assign chan_en   = regs_q.en;
    assign dest_addr = regs_q.dest;
    assign mem_addr  = regs_q.mem;
    assign cnt_nz    = (regs_q.cnt != '0);
    assign irq       = (regs_q.half_flag && regs_q.half_ie) ||
                       (regs_q.done_flag && regs_q.done_ie);

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (regs_q.cnt == $past(regs_q.cnt) - CNT_ONE));

    // R8
    no_step_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (regs_q.cnt != '0));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.done_flag && !(reg_wr && reg_sel == SEL_STAT && reg_wdata[STAT_DONE]))
        |=> regs_q.done_flag);

    // R3
    dest_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.en |=> $stable(regs_q.dest));

endmodule

// File: rtl/dma_m2p_engine.sv
module dma_m2p_engine
    import dma_m2p_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_en,
    input  logic          cnt_nz,
    input  logic          periph_req,
    input  logic [AW-1:0] dest_addr,
    input  logic [AW-1:0] mem_addr,
    input  logic          mst_ready,
    input  logic [DW-1:0] mst_rdata,
    output logic          mst_valid,
    output logic          mst_we,
    output logic [AW-1:0] mst_addr,
    output logic [DW-1:0] mst_wdata,
    output logic          periph_ack,
    output logic          step,
    output logic          busy
);

    typedef struct packed {
        phase_e        ph;
        logic [DW-1:0] held;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d      = eng_q;
        mst_valid  = 1'b0;
        mst_we     = 1'b0;
        mst_addr   = '0;
        mst_wdata  = '0;
        periph_ack = 1'b0;
        step       = 1'b0;

        unique case (eng_q.ph)
            PH_IDLE: begin
                if (chan_en && cnt_nz && periph_req) eng_d.ph = PH_READ;
            end
            PH_READ: begin
                mst_valid = 1'b1;
                mst_addr  = mem_addr;
                if (mst_ready) begin
                    eng_d.held = mst_rdata;
                    eng_d.ph   = PH_WRITE;
                end
            end
            PH_WRITE: begin
                mst_valid = 1'b1;
                mst_we    = 1'b1;
                mst_addr  = dest_addr;
                mst_wdata = eng_q.held;
                if (mst_ready) begin
                    periph_ack = 1'b1;
                    step       = 1'b1;
                    eng_d.ph   = PH_IDLE;
                end
            end
            default: eng_d.ph = PH_IDLE;
        endcase
    end

    assign busy = (eng_q.ph != PH_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{ph: PH_IDLE, held: '0};
        else        eng_q <= eng_d;
    end

    // R5
    hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_valid && !mst_ready) |=>
        (mst_valid && $stable(mst_we) && $stable(mst_addr) && $stable(mst_wdata)));

    // R6
    ack_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |-> (mst_valid && mst_we && mst_ready));

    // R4
    read_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mst_we) |-> $past(mst_valid && !mst_we && mst_ready));

endmodule

// File: rtl/dma_chan_m2p.sv
module dma_chan_m2p
    import dma_m2p_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int PRIO_W = 2,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              periph_req,
    output logic              periph_ack,
    output logic              mst_valid,
    output logic              mst_we,
    output logic [ADDR_W-1:0] mst_addr,
    output logic [DATA_W-1:0] mst_wdata,
    input  logic [DATA_W-1:0] mst_rdata,
    input  logic              mst_ready,
    output logic              irq
);

    logic              chan_en;
    logic              cnt_nz;
    logic              step;
    logic              busy;
    logic [ADDR_W-1:0] dest_addr;
    logic [ADDR_W-1:0] mem_addr;

    dma_m2p_regs #(
        .AW    (ADDR_W),
        .CW    (CNT_W),
        .PW    (PRIO_W),
        .REG_W (REG_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .step      (step),
        .busy      (busy),
        .chan_en   (chan_en),
        .dest_addr (dest_addr),
        .mem_addr  (mem_addr),
        .cnt_nz    (cnt_nz),
        .irq       (irq)
    );

    dma_m2p_engine #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .cnt_nz     (cnt_nz),
        .periph_req (periph_req),
        .dest_addr  (dest_addr),
        .mem_addr   (mem_addr),
        .mst_ready  (mst_ready),
        .mst_rdata  (mst_rdata),
        .mst_valid  (mst_valid),
        .mst_we     (mst_we),
        .mst_addr   (mst_addr),
        .mst_wdata  (mst_wdata),
        .periph_ack (periph_ack),
        .step       (step),
        .busy       (busy)
    );

    // R10
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(step || reg_wr));

endmodule

// File: tb/dma_chan_m2p_bench.sv
module dma_chan_m2p_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        periph_req = 1'b0;
    logic        periph_ack;
    logic        mst_valid;
    logic        mst_we;
    logic [31:0] mst_addr;
    logic [7:0]  mst_wdata;
    logic [7:0]  mst_rdata;
    logic        mst_ready = 1'b1;
    logic        irq;

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_at(input logic [31:0] a);
        return a[7:0] * 8'd29 + 8'd5;
    endfunction

    assign mst_rdata = mem_at(mst_addr);

    dma_chan_m2p u_dma_chan_m2p (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
        .periph_ack(periph_ack), .mst_valid(mst_valid), .mst_we(mst_we),
        .mst_addr(mst_addr), .mst_wdata(mst_wdata), .mst_rdata(mst_rdata),
        .mst_ready(mst_ready), .irq(irq)
    );

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int pend    = 0;
    bit fast    = 1'b0;
    bit valid_seen = 1'b0;
    bit done_flag  = 1'b0;

    // behavioural model state
    bit          m_en, m_hie, m_tie, m_hf, m_df;
    logic [1:0]  m_prio;
    logic [31:0] m_dest, m_mem;
    logic [15:0] m_cnt, m_half;
    int          m_ph;
    logic [7:0]  m_byte;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        m_en = 0; m_hie = 0; m_tie = 0; m_hf = 0; m_df = 0; m_prio = 0;
        m_dest = 0; m_mem = 0; m_cnt = 0; m_half = 0; m_ph = 0; m_byte = 0;
    endtask

    task automatic model_step();
        bit cfg_ok;
        bit fin;
        int nph;
        cfg_ok = !m_en && (m_ph == 0);
        fin    = (m_ph == 2) && mst_ready;
        nph    = m_ph;
        if (m_ph == 0 && m_en && m_cnt != 0 && periph_req) nph = 1;
        else if (m_ph == 1 && mst_ready) begin nph = 2; m_byte = mem_at(m_mem); end
        else if (fin) nph = 0;
        if (reg_wr) begin
            case (reg_sel)
                3'd0: begin
                    m_en = reg_wdata[0];
                    if (cfg_ok) begin m_hie = reg_wdata[1]; m_tie = reg_wdata[2]; m_prio = reg_wdata[5:4]; end
                end
                3'd1: if (cfg_ok) m_dest = reg_wdata;
                3'd2: if (cfg_ok) m_mem = reg_wdata;
                3'd3: if (cfg_ok) begin m_cnt = reg_wdata[15:0]; m_half = reg_wdata[15:0] / 2; end
                3'd4: begin if (reg_wdata[0]) m_hf = 0; if (reg_wdata[1]) m_df = 0; end
                default: ;
            endcase
        end
        if (fin) begin
            m_cnt = m_cnt - 1;
            m_mem = m_mem + 1;
            if (m_cnt == m_half) m_hf = 1;
            if (m_cnt == 0) m_df = 1;
            if (pend > 0) pend--;
        end
        m_ph = nph;
    endtask

    function automatic logic [31:0] model_rd(input logic [2:0] s);
        case (s)
            3'd0: return {26'd0, m_prio, 1'b0, m_tie, m_hie, m_en};
            3'd1: return m_dest;
            3'd2: return m_mem;
            3'd3: return {16'd0, m_cnt};
            3'd4: return {30'd0, m_df, m_hf};
            default: return 32'd0;
        endcase
    endfunction

    task automatic compare_all();
        check("R4 mst_valid", {31'd0, mst_valid}, {31'd0, m_ph != 0});
        check("R4 mst_we", {31'd0, mst_we}, {31'd0, m_ph == 2});
        check("R4 mst_addr", mst_addr, (m_ph == 1) ? m_mem : (m_ph == 2) ? m_dest : 32'd0);
        check("R5 mst_wdata", {24'd0, mst_wdata}, {24'd0, (m_ph == 2) ? m_byte : 8'd0});
        check("R6 periph_ack", {31'd0, periph_ack}, {31'd0, (m_ph == 2) && mst_ready});
        check("R10 irq", {31'd0, irq}, {31'd0, (m_hf && m_hie) || (m_df && m_tie)});
        check("R2 reg_rdata", reg_rdata, model_rd(reg_sel));
        if (mst_valid) valid_seen = 1'b1;
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (!rst_n) model_reset(); else model_step();
        compare_all();
        mst_ready  = fast ? 1'b1 : ((cyc % 3) != 0);
        periph_req = (pend > 0);
    endtask

    task automatic reg_write(input logic [2:0] s, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] s, output logic [31:0] v);
        reg_sel = s;
        tick();
        v = reg_rdata;
    endtask

    task automatic drain();
        for (int g = 0; g < 400 && pend > 0; g++) tick();
        repeat (4) tick();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        model_reset();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 mst_valid", {31'd0, mst_valid}, 32'd0);
        for (int s = 0; s < 5; s++) begin
            reg_read(s[2:0], v);
            check("R1 register zero", v, 32'd0);
        end

        // R2: programming and readback
        reg_write(3'd1, 32'h4000_1008);
        reg_write(3'd2, 32'h0000_0020);
        reg_write(3'd3, 32'd5);
        reg_write(3'd0, 32'h26);
        reg_write(3'd0, 32'h27);
        reg_read(3'd0, v); check("R2 ctrl readback", v, 32'h27);
        reg_read(3'd1, v); check("R2 dest readback", v, 32'h4000_1008);
        reg_read(3'd7, v); check("R2 unused select", v, 32'd0);

        // R3: configuration frozen while enabled
        reg_write(3'd3, 32'd9);
        reg_read(3'd3, v); check("R3 count frozen", v, 32'd5);
        reg_write(3'd1, 32'h0000_0123);
        reg_read(3'd1, v); check("R3 dest frozen", v, 32'h4000_1008);
        reg_write(3'd0, 32'h21);
        reg_read(3'd0, v); check("R3 ctrl fields frozen", v, 32'h27);

        // R4 R5 R6 R7: three bytes with a stalling memory port
        fast = 1'b0;
        pend = 3;
        drain();
        reg_read(3'd3, v); check("R6 count after 3", v, 32'd2);
        reg_read(3'd2, v); check("R6 mem addr after 3", v, 32'h23);
        reg_read(3'd4, v); check("R7 half flag at floor(5/2)", v, 32'd1);
        check("R10 irq on half", {31'd0, irq}, 32'd1);

        // R8: completion
        pend = 2;
        drain();
        reg_read(3'd4, v); check("R8 complete flag", v, 32'd3);
        reg_read(3'd3, v); check("R8 count zero", v, 32'd0);
        reg_read(3'd1, v); check("R6 dest unchanged", v, 32'h4000_1008);

        // R8: requests after completion are ignored
        valid_seen = 1'b0;
        pend = 3;
        repeat (30) tick();
        check("R8 no bus traffic after completion", {31'd0, valid_seen}, 32'd0);
        pend = 0;
        reg_read(3'd2, v); check("R8 mem addr stays", v, 32'h25);

        // R9 R10: write-one-to-clear
        reg_write(3'd4, 32'd1);
        reg_read(3'd4, v); check("R9 half cleared only", v, 32'd2);
        check("R10 irq from completion", {31'd0, irq}, 32'd1);
        reg_write(3'd4, 32'd2);
        reg_read(3'd4, v); check("R9 both cleared", v, 32'd0);
        check("R10 irq low", {31'd0, irq}, 32'd0);

        // R7 R10: count 4, half-way enable only, fast memory
        reg_write(3'd0, 32'h0);
        reg_read(3'd0, v); check("R3 enable always writable", v, 32'h26);
        reg_write(3'd2, 32'h30);
        reg_write(3'd3, 32'd4);
        reg_write(3'd0, 32'h02);
        reg_write(3'd0, 32'h03);
        fast = 1'b1;
        pend = 2;
        drain();
        reg_read(3'd4, v); check("R7 half flag at 2 of 4", v, 32'd1);
        check("R10 irq half enabled", {31'd0, irq}, 32'd1);
        pend = 2;
        drain();
        reg_write(3'd4, 32'd1);
        reg_read(3'd4, v); check("R9 completion remains", v, 32'd2);
        check("R10 completion irq disabled", {31'd0, irq}, 32'd0);

        // R7: single-byte run sets both flags together
        reg_write(3'd0, 32'h0);
        reg_write(3'd4, 32'd3);
        reg_write(3'd3, 32'd1);
        reg_write(3'd0, 32'h05);
        pend = 1;
        drain();
        reg_read(3'd4, v); check("R7 N=1 both flags", v, 32'd3);
        check("R10 irq completion", {31'd0, irq}, 32'd1);

        // R8: zero count never starts
        reg_write(3'd0, 32'h0);
        reg_write(3'd4, 32'd3);
        reg_write(3'd3, 32'd0);
        reg_write(3'd0, 32'h01);
        valid_seen = 1'b0;
        pend = 2;
        repeat (20) tick();
        pend = 0;
        check("R8 zero count idle", {31'd0, valid_seen}, 32'd0);
        reg_read(3'd4, v); check("R8 zero count no flags", v, 32'd0);

        repeat (3) tick();
        finish_run();
    end

endmodule